// File: doc/BRIEF.md
# Pipelined-Reply SPI Command Slave

This block is the command-side model of an eight-output driver chip, used as the partner of a sequencer that talks to it over a 16-bit SPI link in mode 0. Each frame carries a 4-bit command code in its top nibble and a 12-bit payload. Write commands store their payload in a small configuration register file. A read command selects a register, and a check command asks for a fixed acknowledge word.

The reply to a frame is never the answer to that frame. While frame N is being exchanged, the slave shifts out the answer to frame N-1. After any write, the answer is the all-status word. That word is built from three 4-bit fault inputs, which the testbench or the surrounding model drives. Four diagnostic words are also loadable from inputs and can be read back by address.

The SPI pins are oversampled in the system clock domain, so SCLK must run well below the system clock. A frame takes effect only if exactly sixteen SCLK rising edges occur while chip select is low.

Top module: `spi_cmd_slave`

## Requirements
- R1: A frame is accepted only when exactly 16 SCLK rising edges occur between the falling and the rising edge of `spi_cs_n`. A frame with any other count changes no stored register, no pending reply and no flag.
- R2: `spi_miso_oe` is low while chip select is high. During a frame, `spi_miso` presents the reply MSB first. Bit 15 is valid from the start of the frame, and each following bit appears after a falling SCLK edge. MOSI is sampled on rising SCLK.
- R3: The check command, code 0x0 with bits 11:8 = 0xF, makes the next reply exactly 0x0D0A, with no flag bits.
- R4: After a write command (codes 0x1 to 0xA) or the calibration command (code 0xE), the next reply is the all-status word {flags[15:12], ign_flt[11:8], gd_flt[7:4], out_flt[3:0]}. The fault fields are sampled when chip select falls.
- R5: A read command, code 0x0 with bits 11:8 = 0xA and the address in bits 7:4, makes the next reply the addressed register. Addresses 0x5 to 0xE return the stored payload of write code (address - 4).
- R6: Stored payloads are masked by command code. Code 0x3 keeps bits 7:0. Code 0x5 keeps bits 1:0. Code 0x9 keeps the bits of mask 0x0F0F. Every other write code keeps bits 11:0.
- R7: Read address 0x0 returns the all-status word. Addresses 0x1 to 0x4 return `diag_w[0]` to `diag_w[3]`. Address 0xF returns the revision parameter. All of these sit in bits 11:0.
- R8: Reply bit 15 is set by reset. It is carried in every non-acknowledge reply until an accepted frame has shifted it out, and is then clear.
- R9: An undefined command (codes 0xB, 0xC, 0xD, 0xF, or code 0x0 with bits 11:8 other than 0xA or 0xF) makes the next reply the all-status word with bit 14 set. Bit 14 is clear after any defined command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Command bits, MSB first |
| spi_miso | output | 1 | Reply bits, MSB first |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` |
| out_flt | input | 4 | Output-stage fault flags for the all-status word |
| gd_flt | input | 4 | Gate-driver fault flags for the all-status word |
| ign_flt | input | 4 | Ignition fault flags for the all-status word |
| diag_w | input | 4x12 | Diagnostic words returned by read addresses 1 to 4 |

## Verification
The assertions assume that SCLK and chip select change slowly compared with `clk`, so every SPI edge is seen by the synchronisers. They also assume that chip select never rises and falls within one synchronised sample, which would merge a frame end with a frame start. The stimulus holds each SCLK level and each chip-select change for several system clocks. It changes MOSI only while SCLK is low, and it changes the fault inputs only between frames. Short and long frames are sent on purpose, to show that a rejected frame leaves the reply pipeline and the register file untouched.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int FRAME_W = 16;
  localparam int PAY_W   = 12;
  localparam int NCH     = 4;
  localparam int IDX_W   = 4;

  typedef enum logic [1:0] {
    K_ALL   = 2'd0,
    K_CHECK = 2'd1,
    K_REG   = 2'd2
  } reply_kind_t;

  localparam logic [3:0]         OP_CTRL   = 4'h0;
  localparam logic [3:0]         OP_CAL    = 4'hE;
  localparam logic [3:0]         SUB_READ  = 4'hA;
  localparam logic [3:0]         SUB_CHECK = 4'hF;
  localparam logic [FRAME_W-1:0] CHECK_ACK = 16'h0D0A;

  function automatic logic op_is_write(input logic [3:0] op);
    return (op >= 4'h1) && (op <= 4'hA);
  endfunction

  function automatic logic [PAY_W-1:0] keep_mask(input logic [3:0] op);
    case (op)
      4'h3:    return 12'h0FF;
      4'h5:    return 12'h003;
      4'h9:    return 12'hF0F;
      default: return 12'hFFF;
    endcase
  endfunction
endpackage

// File: rtl/spi_frame_port.sv
module spi_frame_port #(
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          mosi,
  input  logic [FW-1:0] tx_word,
  output logic          load,
  output logic          commit,
  output logic [FW-1:0] rx_word,
  output logic          cs_idle,
  output logic          miso,
  output logic          miso_oe
);
  localparam int CNT_W = $clog2(FW + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FW);
  localparam logic [CNT_W-1:0] CNT_OVR  = CNT_W'(FW + 1);

  logic [2:0]       sclk_s, cs_s;
  logic [1:0]       mosi_s;
  logic [CNT_W-1:0] cnt;
  logic [FW-1:0]    rx_sh, tx_sh;
  logic             s_rise, s_fall, c_fell, c_rose;

  assign s_rise  = sclk_s[1] & ~sclk_s[2];
  assign s_fall  = ~sclk_s[1] & sclk_s[2];
  assign c_fell  = ~cs_s[1] & cs_s[2];
  assign c_rose  = cs_s[1] & ~cs_s[2];
  assign cs_idle = cs_s[1];
  assign load    = c_fell;
  assign rx_word = rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_s  <= '0;
      cs_s    <= '1;
      mosi_s  <= '0;
      cnt     <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
      commit  <= 1'b0;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk};
      cs_s   <= {cs_s[1:0], cs_n};
      mosi_s <= {mosi_s[0], mosi};
      commit <= c_rose && (cnt == CNT_FULL);
      if (c_fell) begin
        cnt     <= '0;
        tx_sh   <= tx_word;
        miso    <= tx_word[FW-1];
        miso_oe <= 1'b1;
      end else if (c_rose) begin
        miso_oe <= 1'b0;
      end else if (!cs_s[1]) begin
        if (s_rise) begin
          rx_sh <= {rx_sh[FW-2:0], mosi_s[1]};
          if (cnt != CNT_OVR) cnt <= cnt + 1'b1;
        end
        if (s_fall) begin
          tx_sh <= {tx_sh[FW-2:0], 1'b0};
          miso  <= tx_sh[FW-2];
        end
      end
    end
  end
endmodule

// File: rtl/spi_cmd_regfile.sv
module spi_cmd_regfile #(
  parameter int W  = 12,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spi_reply_ctrl.sv
module spi_reply_ctrl
  import spi_cmd_pkg::*;
#(
  parameter logic [PAY_W-1:0] REV_ID = 12'h0C1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       commit,
  input  logic                       load,
  input  logic [FRAME_W-1:0]         rx_word,
  input  logic [PAY_W-1:0]           rd_data,
  input  logic [NCH-1:0]             out_flt,
  input  logic [NCH-1:0]             gd_flt,
  input  logic [NCH-1:0]             ign_flt,
  input  logic [NCH-1:0][PAY_W-1:0]  diag_w,
  output logic [FRAME_W-1:0]         tx_word,
  output logic                       wr_en,
  output logic [IDX_W-1:0]           wr_idx,
  output logic [PAY_W-1:0]           wr_data,
  output logic [IDX_W-1:0]           rd_idx,
  output reply_kind_t                kind_q,
  output logic                       cor_q,
  output logic                       rst_flag_q
);
  logic [3:0]       op, sub, rad, addr_q;
  reply_kind_t      nk;
  logic [3:0]       na;
  logic             ncor, shown_q;
  logic [PAY_W-1:0] stat_word, body;

  assign op  = rx_word[15:12];
  assign sub = rx_word[11:8];
  assign rad = rx_word[7:4];

  always_comb begin
    nk   = K_ALL;
    na   = addr_q;
    ncor = 1'b0;
    if (op == OP_CTRL) begin
      if (sub == SUB_READ) begin
        nk = K_REG;
        na = rad;
      end else if (sub == SUB_CHECK) begin
        nk = K_CHECK;
      end else begin
        ncor = 1'b1;
      end
    end else if (!op_is_write(op) && op != OP_CAL) begin
      ncor = 1'b1;
    end
  end

  assign wr_en   = commit && op_is_write(op);
  assign wr_idx  = op - 4'd1;
  assign wr_data = rx_word[PAY_W-1:0] & keep_mask(op);
  assign rd_idx  = addr_q - 4'd5;

  assign stat_word = {ign_flt, gd_flt, out_flt};

  always_comb begin
    body = stat_word;
    if (kind_q == K_REG) begin
      if (addr_q == 4'h0)                       body = stat_word;
      else if (addr_q <= 4'(NCH))               body = diag_w[addr_q[1:0] - 2'd1];
      else if (addr_q == 4'hF)                  body = REV_ID;
      else                                      body = rd_data;
    end
  end

  assign tx_word = (kind_q == K_CHECK) ? CHECK_ACK
                                       : {rst_flag_q, cor_q, 2'b00, body};

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q     <= K_ALL;
      addr_q     <= '0;
      cor_q      <= 1'b0;
      rst_flag_q <= 1'b1;
      shown_q    <= 1'b0;
    end else begin
      if (load) shown_q <= rst_flag_q && (kind_q != K_CHECK);
      if (commit) begin
        kind_q  <= nk;
        addr_q  <= na;
        cor_q   <= ncor;
        shown_q <= 1'b0;
        if (shown_q) rst_flag_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
  import spi_cmd_pkg::*;
#(
  parameter logic [PAY_W-1:0] REV_ID = 12'h0C1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      spi_sclk,
  input  logic                      spi_cs_n,
  input  logic                      spi_mosi,
  output logic                      spi_miso,
  output logic                      spi_miso_oe,
  input  logic [NCH-1:0]            out_flt,
  input  logic [NCH-1:0]            gd_flt,
  input  logic [NCH-1:0]            ign_flt,
  input  logic [NCH-1:0][PAY_W-1:0] diag_w
);
  logic [FRAME_W-1:0] tx_word, rx_word;
  logic               load, commit, cs_idle;
  logic               wr_en;
  logic [IDX_W-1:0]   wr_idx, rd_idx;
  logic [PAY_W-1:0]   wr_data, rd_data;
  reply_kind_t        pend_kind;
  logic               cor_pend, flag_rst;

  spi_frame_port #(.FW(FRAME_W)) u_port (
    .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .tx_word(tx_word), .load(load), .commit(commit), .rx_word(rx_word),
    .cs_idle(cs_idle), .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  spi_cmd_regfile #(.W(PAY_W), .AW(IDX_W)) u_regs (
    .clk(clk), .we(wr_en), .waddr(wr_idx), .wdata(wr_data),
    .raddr(rd_idx), .rdata(rd_data)
  );

  spi_reply_ctrl #(.REV_ID(REV_ID)) u_reply (
    .clk(clk), .rst(rst), .commit(commit), .load(load), .rx_word(rx_word),
    .rd_data(rd_data), .out_flt(out_flt), .gd_flt(gd_flt), .ign_flt(ign_flt),
    .diag_w(diag_w), .tx_word(tx_word), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .kind_q(pend_kind), .cor_q(cor_pend),
    .rst_flag_q(flag_rst)
  );
endmodule

// File: rtl/spi_cmd_slave_chk.sv
module spi_cmd_slave_chk (
  input logic        clk,
  input logic        rst,
  input logic        cs_idle,
  input logic        miso_oe,
  input logic        commit,
  input logic [15:0] rx_word,
  input logic [1:0]  pend_kind,
  input logic        cor_pend,
  input logic        flag_rst
);
  logic undef_cmd, write_cmd;
  assign write_cmd = (rx_word[15:12] >= 4'h1) && (rx_word[15:12] <= 4'hA);
  assign undef_cmd = (rx_word[15:12] inside {4'hB, 4'hC, 4'hD, 4'hF}) ||
                     (rx_word[15:12] == 4'h0 && !(rx_word[11:8] inside {4'hA, 4'hF}));

  p_idle_oe_r2: assert property (@(posedge clk) disable iff (rst)
    cs_idle |=> !miso_oe);

  p_check_ack_r3: assert property (@(posedge clk) disable iff (rst)
    commit && rx_word[15:8] == 8'h0F |=> pend_kind == 2'd1);

  p_write_all_r4: assert property (@(posedge clk) disable iff (rst)
    commit && write_cmd |=> pend_kind == 2'd0 && !cor_pend);

  p_undef_cor_r9: assert property (@(posedge clk) disable iff (rst)
    commit && undef_cmd |=> cor_pend && pend_kind == 2'd0);

  p_rst_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_rst) |-> $past(commit));

  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(pend_kind) && $stable(cor_pend));
endmodule

bind spi_cmd_slave spi_cmd_slave_chk u_chk (
  .clk(clk), .rst(rst), .cs_idle(cs_idle), .miso_oe(spi_miso_oe),
  .commit(commit), .rx_word(rx_word), .pend_kind(pend_kind),
  .cor_pend(cor_pend), .flag_rst(flag_rst)
);

// File: tb/test_spi_cmd_slave.sv
module test_spi_cmd_slave;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe;
  logic [3:0] out_flt = 4'h5, gd_flt = 4'hA, ign_flt = 4'h3;
  logic [3:0][11:0] diag_w = {12'h444, 12'h333, 12'h222, 12'h111};

  int checks = 0, errors = 0;

  typedef struct { logic [15:0] w; string tag; } item_t;
  item_t exp_q[$];
  logic [15:0] act_q[$];

  always #10 clk = ~clk;

  spi_cmd_slave i_spi_cmd_slave (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .out_flt(out_flt),
    .gd_flt(gd_flt), .ign_flt(ign_flt), .diag_w(diag_w)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] tx, input int nclk, output logic [15:0] rx);
    rx = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      mosi = (i < 16) ? tx[15 - i] : 1'b0;
      repeat (4) @(negedge clk);
      if (i < 16) rx[15 - i] = miso;
      if (i == 0) check({15'd0, miso_oe}, 16'd1, "R2 oe in frame");
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
    check({15'd0, miso_oe}, 16'd0, "R2 oe idle");
  endtask

  task automatic send(input logic [15:0] tx, input logic [15:0] exp, input string tag);
    logic [15:0] rx;
    item_t it;
    it.w = exp;
    it.tag = tag;
    exp_q.push_back(it);
    xfer(tx, 16, rx);
    act_q.push_back(rx);
  endtask

  task automatic bad_frame(input logic [15:0] tx, input int n);
    logic [15:0] rx;
    xfer(tx, n, rx);
  endtask

  always @(negedge clk) begin
    if (act_q.size() != 0 && exp_q.size() != 0) begin
      item_t it;
      logic [15:0] a;
      it = exp_q.pop_front();
      a = act_q.pop_front();
      check(a, it.w, it.tag);
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check({15'd0, miso_oe}, 16'd0, "R2 reset oe");
    send(16'h0F00, 16'h83A5, "R8 reset flag in first reply");
    send(16'h1ABC, 16'h0D0A, "R3 check ack");
    send(16'h0A50, 16'h03A5, "R4 status after write, R8 cleared");
    send(16'h3FFF, 16'h0ABC, "R5 read mode register");
    send(16'h5FFF, 16'h03A5, "R4 status after write");
    send(16'h9FFF, 16'h03A5, "R4 status after write");
    send(16'h0A70, 16'h03A5, "R4 status after write");
    send(16'h0A90, 16'h00FF, "R6 driver-enable mask");
    send(16'h0AD0, 16'h0003, "R6 filter mask");
    send(16'h0A10, 16'h0F0F, "R6 fault-op mask");
    send(16'h0A40, 16'h0111, "R7 diag word 0");
    send(16'h0AF0, 16'h0444, "R7 diag word 3");
    send(16'h0A00, 16'h00C1, "R7 revision");
    send(16'hB123, 16'h03A5, "R7 address 0 status");
    send(16'h0A50, 16'h43A5, "R9 undefined code B");
    bad_frame(16'h1555, 15);
    send(16'h0A50, 16'h0ABC, "R1 short frame ignored, R9 cleared");
    send(16'hE000, 16'h0ABC, "R1 short frame wrote nothing");
    send(16'h0000, 16'h03A5, "R4 status after calibration");
    send(16'h0A50, 16'h43A5, "R9 undefined code 0 subcode");
    bad_frame(16'h1777, 17);
    send(16'h0A00, 16'h0ABC, "R1 long frame ignored");
    send(16'h0F00, 16'h03A5, "R7 address 0 status");
    send(16'h0000, 16'h0D0A, "R3 check ack");
    out_flt = 4'hF; gd_flt = 4'h0; ign_flt = 4'h8;
    send(16'h0A00, 16'h480F, "R9 flag with new status pattern R4");
    send(16'h0000, 16'h080F, "R7 address 0 new status");
    repeat (20) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule